// File: doc/BRIEF.md
# Teletext Bit Request Sequencer

This block times the serial data exchange for one teletext line inside a video encoder running on a 27 MHz system clock. At each leading edge of horizontal sync it decides whether the coming line carries teletext. If so, it counts out a fixed offset and then raises a request window toward an external data source. The source answers with one serial bit stream, and the block samples that stream at the teletext bit rate. Each sampled bit is handed to the downstream insertion logic with a one-cycle strobe and its position in the line.

The teletext bit rate is slightly above one quarter of the system clock, so bits cannot be a fixed clock divide. Within every run of 37 bits, four bits last three clocks and the rest last four, which makes 37 bits span exactly 144 clocks. The source has its own pipeline latency of 0 to 15 clocks. The request is raised that many clocks earlier, so the data always lands at the same point after sync whatever that latency is. With the default parameters the window opens 264 minus the programmed latency clocks after the sync cycle. That is the 275-clock insertion point less an 11-clock internal latency.

Top module: `ttx_req_seq`

## Requirements
- R1: While reset is asserted and right after it, `ttx_req` and `bit_strobe` are 0, `bit_index` is 0 and `bit_value` is 0.
- R2: The cycle in which `hsync_lead` is high counts as cycle 0. On an enabled line, `ttx_req` first goes high in cycle 264 minus `src_delay`, and that first cycle is the first clock of bit 0.
- R3: Once open, `ttx_req` stays high for exactly 1402 consecutive cycles, the total length of 360 bits, and is low in the cycle after.
- R4: Bit periods follow a cadence that repeats every 37 bits. Counting bits from 0 inside each group of 37, bits 9, 18, 27 and 36 last three clocks and every other bit lasts four. Consecutive strobes are therefore 3 or 4 cycles apart.
- R5: Each bit is sampled from `ttx_in` during its second clock. The sample appears on `bit_value`, with `bit_strobe` high, in the cycle after that.
- R6: A full line produces exactly 360 strobes, with `bit_index` running 0, 1, 2 … 359 in order.
- R7: If `ttx_global_en` is 0 in the sync cycle, no window opens and no strobe appears for that line.
- R8: If `line_ttx_en` is 0 in the sync cycle, no window opens and no strobe appears for that line.
- R9: A sync pulse while the window is open aborts the line. `ttx_req` is low in the next cycle, no strobe comes from a bit sampled in the sync cycle, and a fresh window opens at the R2 offset counted from the new sync.
- R10: A sync pulse during the wait before the window restarts the offset count from the new sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_lead | input | 1 | One-cycle pulse on the leading edge of horizontal sync |
| ttx_global_en | input | 1 | Global teletext enable, sampled at sync |
| line_ttx_en | input | 1 | Teletext enable for the coming line, sampled at sync |
| src_delay | input | 4 | Source latency from request to data, in clocks (0 to 15) |
| ttx_in | input | 1 | Serial teletext data from the source |
| ttx_req | output | 1 | Data request window toward the source |
| bit_strobe | output | 1 | One-cycle valid for a sampled bit |
| bit_value | output | 1 | Sampled teletext bit |
| bit_index | output | 9 | Position of the sampled bit in the line (0 to 359) |

## Verification
The hardest condition to reach from the ports is a sync pulse that lands exactly on the second clock of a bit inside an open window. In that cycle a sample would be taken and must be dropped. The bench computes the bench-side start cycle of bit 100 and raises sync in the cycle the sample would be taken. It then checks that no strobe leaks into the restarted line and that the new window opens at its own offset. The data pattern on `ttx_in` changes with the cycle number, so sampling one clock early or late shows up as wrong values.

// File: rtl/ttx_seq_pkg.sv
package ttx_seq_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_WAIT = 2'd1,
    LS_RUN  = 2'd2
  } line_state_e;

  // Cycle, counted from the sync cycle, in which the request first goes high.
  function automatic int unsigned window_start(input int unsigned insert_clks,
                                               input int unsigned pipe_lat,
                                               input int unsigned delay);
    return insert_clks - pipe_lat - delay;
  endfunction

  // A bit is short when its position in the group is a nonzero multiple of the stride.
  function automatic logic short_bit(input int unsigned gpos, input int unsigned stride);
    return (gpos != 0) && ((gpos % stride) == 0);
  endfunction

endpackage

// File: rtl/ttx_line_ctrl.sv
module ttx_line_ctrl
  import ttx_seq_pkg::*;
#(
  parameter int INSERT_CLKS = 275,
  parameter int PIPE_LAT    = 11,
  parameter int DELAY_W     = 4,
  parameter int CNT_W       = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync,
  input  logic               global_en,
  input  logic               line_en,
  input  logic [DELAY_W-1:0] delay,
  input  logic               line_last,
  output logic               run_active,
  output logic               waiting
);

  line_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] open_m1;
  logic             armed;

  assign armed   = global_en & line_en;
  assign open_m1 = CNT_W'(window_start(INSERT_CLKS, PIPE_LAT, int'(delay)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= LS_IDLE;
      cnt <= '0;
    end else if (sync) begin
      st  <= armed ? LS_WAIT : LS_IDLE;
      cnt <= CNT_W'(1);
    end else begin
      case (st)
        LS_WAIT: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == open_m1) st <= LS_RUN;
        end
        LS_RUN: begin
          if (line_last) st <= LS_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign run_active = (st == LS_RUN);
  assign waiting    = (st == LS_WAIT);

endmodule

// File: rtl/ttx_bit_cadence.sv
module ttx_bit_cadence
  import ttx_seq_pkg::*;
#(
  parameter int LINE_BITS    = 360,
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_CLKS    = 4,
  parameter int IDX_W        = 9,
  parameter int GPOS_W       = 6,
  parameter int PH_W         = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_active,
  input  logic             sync,
  output logic             sample_now,
  output logic             bit_first,
  output logic             line_last,
  output logic [IDX_W-1:0] cur_idx
);

  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   last_ph;
  logic [GPOS_W-1:0] gpos;
  logic [IDX_W-1:0]  idx;
  logic              is_short;
  logic              bit_last;

  assign is_short   = short_bit(int'(gpos), SHORT_STRIDE);
  assign last_ph    = is_short ? PH_W'(LONG_CLKS - 2) : PH_W'(LONG_CLKS - 1);
  assign bit_last   = (phase == last_ph);
  assign line_last  = run_active && bit_last && (idx == IDX_W'(LINE_BITS - 1));
  assign sample_now = run_active && !sync && (phase == PH_W'(1));
  assign bit_first  = run_active && (phase == '0) && (idx == '0);
  assign cur_idx    = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      gpos  <= '0;
      idx   <= '0;
    end else if (!run_active || sync) begin
      phase <= '0;
      gpos  <= '0;
      idx   <= '0;
    end else if (bit_last) begin
      phase <= '0;
      idx   <= idx + IDX_W'(1);
      gpos  <= (gpos == GPOS_W'(GROUP_BITS - 1)) ? '0 : gpos + GPOS_W'(1);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

endmodule

// File: rtl/ttx_bit_sampler.sv
module ttx_bit_sampler #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_now,
  input  logic             din,
  input  logic [IDX_W-1:0] idx,
  output logic             strobe,
  output logic             value,
  output logic [IDX_W-1:0] index
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      value  <= 1'b0;
      index  <= '0;
    end else begin
      strobe <= sample_now;
      if (sample_now) begin
        value <= din;
        index <= idx;
      end
    end
  end

endmodule

// File: rtl/ttx_req_seq.sv
module ttx_req_seq #(
  parameter int LINE_BITS    = 360,
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_CLKS    = 4,
  parameter int INSERT_CLKS  = 275,
  parameter int PIPE_LAT     = 11,
  parameter int DELAY_W      = 4,
  localparam int IDX_W       = $clog2(LINE_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_lead,
  input  logic               ttx_global_en,
  input  logic               line_ttx_en,
  input  logic [DELAY_W-1:0] src_delay,
  input  logic               ttx_in,
  output logic               ttx_req,
  output logic               bit_strobe,
  output logic               bit_value,
  output logic [IDX_W-1:0]   bit_index
);

  localparam int CNT_W  = $clog2(INSERT_CLKS + 1);
  localparam int GPOS_W = $clog2(GROUP_BITS);
  localparam int PH_W   = $clog2(LONG_CLKS);

  logic             run_active_w;
  logic             waiting_w;
  logic             sample_now_w;
  logic             bit_first_w;
  logic             line_last_w;
  logic [IDX_W-1:0] cur_idx_w;

  ttx_line_ctrl #(
    .INSERT_CLKS (INSERT_CLKS),
    .PIPE_LAT    (PIPE_LAT),
    .DELAY_W     (DELAY_W),
    .CNT_W       (CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync       (hsync_lead),
    .global_en  (ttx_global_en),
    .line_en    (line_ttx_en),
    .delay      (src_delay),
    .line_last  (line_last_w),
    .run_active (run_active_w),
    .waiting    (waiting_w)
  );

  ttx_bit_cadence #(
    .LINE_BITS    (LINE_BITS),
    .GROUP_BITS   (GROUP_BITS),
    .SHORT_STRIDE (SHORT_STRIDE),
    .LONG_CLKS    (LONG_CLKS),
    .IDX_W        (IDX_W),
    .GPOS_W       (GPOS_W),
    .PH_W         (PH_W)
  ) cad_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_active (run_active_w),
    .sync       (hsync_lead),
    .sample_now (sample_now_w),
    .bit_first  (bit_first_w),
    .line_last  (line_last_w),
    .cur_idx    (cur_idx_w)
  );

  ttx_bit_sampler #(
    .IDX_W (IDX_W)
  ) smp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_now (sample_now_w),
    .din        (ttx_in),
    .idx        (cur_idx_w),
    .strobe     (bit_strobe),
    .value      (bit_value),
    .index      (bit_index)
  );

  assign ttx_req = run_active_w;

endmodule

// File: rtl/ttx_req_seq_chk.sv
module ttx_req_seq_chk #(
  parameter int LINE_BITS = 360,
  parameter int IDX_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync_lead,
  input logic             ttx_global_en,
  input logic             line_ttx_en,
  input logic             ttx_req,
  input logic             bit_strobe,
  input logic [IDX_W-1:0] bit_index,
  input logic             waiting,
  input logic             bit_first
);

  logic             seen;
  logic [3:0]       gap;
  logic [IDX_W-1:0] prev_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      gap      <= '0;
      prev_idx <= '0;
    end else if (hsync_lead) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (bit_strobe) begin
      seen     <= 1'b1;
      gap      <= 4'd1;
      prev_idx <= bit_index;
    end else if (gap != 4'hF) begin
      gap <= gap + 4'd1;
    end
  end

  assert_open_at_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ttx_req) |-> bit_first);

  assert_gap_three_or_four_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && seen) |-> (gap == 4'd3 || gap == 4'd4));

  assert_strobe_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> $past(ttx_req));

  assert_index_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && seen) |-> (bit_index == prev_idx + IDX_W'(1)));

  assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (bit_index < IDX_W'(LINE_BITS)));

  assert_global_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_lead && !ttx_global_en) |=> (!waiting && !ttx_req));

  assert_line_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_lead && !line_ttx_en) |=> (!waiting && !ttx_req));

  assert_sync_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_lead |=> !ttx_req);

endmodule

bind ttx_req_seq ttx_req_seq_chk #(
  .LINE_BITS (LINE_BITS),
  .IDX_W     (IDX_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .hsync_lead    (hsync_lead),
  .ttx_global_en (ttx_global_en),
  .line_ttx_en   (line_ttx_en),
  .ttx_req       (ttx_req),
  .bit_strobe    (bit_strobe),
  .bit_index     (bit_index),
  .waiting       (waiting_w),
  .bit_first     (bit_first_w)
);

// File: tb/ttx_req_seq_tb_top.sv
`timescale 1ns/1ps
module ttx_req_seq_tb_top;

  localparam int BASE     = 264;
  localparam int LINE_CLK = 1402;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_lead = 1'b0;
  logic       ttx_global_en = 1'b0;
  logic       line_ttx_en = 1'b0;
  logic [3:0] src_delay = 4'd0;
  logic       ttx_in = 1'b0;
  logic       ttx_req;
  logic       bit_strobe;
  logic       bit_value;
  logic [8:0] bit_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ttx_req_seq dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hsync_lead    (hsync_lead),
    .ttx_global_en (ttx_global_en),
    .line_ttx_en   (line_ttx_en),
    .src_delay     (src_delay),
    .ttx_in        (ttx_in),
    .ttx_req       (ttx_req),
    .bit_strobe    (bit_strobe),
    .bit_value     (bit_value),
    .bit_index     (bit_index)
  );

  // {global_en, line_en, delay[3:0], window_expected}
  localparam logic [6:0] VECS [0:6] = '{
    7'b1_1_0000_1,
    7'b1_1_1111_1,
    7'b1_1_0111_1,
    7'b0_1_0011_0,
    7'b1_0_0011_0,
    7'b0_0_0000_0,
    7'b1_1_0001_1
  };

  function automatic logic pat(input int c);
    return c[0] ^ c[3] ^ c[6];
  endfunction

  // Start of bit k relative to window open: 144 clocks per 37 bits,
  // minus one clock for each short bit already passed in the group.
  function automatic int bstart(input int k);
    int p;
    p = k % 37;
    return 144 * (k / 37) + 4 * p - ((p == 0) ? 0 : (p - 1) / 9);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drives sync in the current cycle (cycle 0) and observes cycles 1..stop_at.
  task automatic run_line(input logic g, input logic l, input logic [3:0] dly,
                          input logic open_exp, input int stop_at, input string tag);
    int s;
    int kn;
    int req_err;
    int stb_err;
    int dat_err;
    int nstb;
    logic exp_req;
    logic exp_stb;
    s = BASE - int'(dly);
    kn = 0; req_err = 0; stb_err = 0; dat_err = 0; nstb = 0;
    hsync_lead = 1'b1;
    ttx_global_en = g;
    line_ttx_en = l;
    src_delay = dly;
    ttx_in = pat(0);
    for (int c = 1; c <= stop_at; c++) begin
      @(negedge clk);
      exp_req = open_exp && (c >= s) && (c < s + LINE_CLK);
      if (ttx_req !== exp_req) req_err++;
      exp_stb = open_exp && (kn < 360) && (c == s + bstart(kn) + 2);
      if (bit_strobe === 1'b1) nstb++;
      if (bit_strobe !== exp_stb) stb_err++;
      else if (exp_stb) begin
        if (bit_index !== 9'(kn) || bit_value !== pat(c - 1)) dat_err++;
        kn++;
      end
      if (c != stop_at) begin
        hsync_lead = 1'b0;
        ttx_in = pat(c);
      end
    end
    check(req_err == 0, {tag, " R2 R3 request window cycles wrong"}, req_err, 0);
    check(stb_err == 0, {tag, " R4 strobe cadence wrong"}, stb_err, 0);
    check(dat_err == 0, {tag, " R5 sampled value or index wrong"}, dat_err, 0);
    check(nstb == kn, {tag, " R6 strobe count"}, nstb, kn);
    if (stop_at >= s + LINE_CLK + 2)
      check(kn == (open_exp ? 360 : 0), {tag, " R6 full line bit count"}, kn, open_exp ? 360 : 0);
  endtask

  initial begin
    int s5;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ttx_req === 1'b0, "R1 ttx_req in reset", int'(ttx_req), 0);
    check(bit_strobe === 1'b0, "R1 bit_strobe in reset", int'(bit_strobe), 0);
    check(bit_index === 9'd0 && bit_value === 1'b0, "R1 index/value in reset",
          int'(bit_index), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ttx_req === 1'b0 && bit_strobe === 1'b0, "R1 outputs after reset",
          int'(ttx_req), 0);

    // Table-driven lines: R2..R8
    for (int i = 0; i < 7; i++) begin
      logic [6:0] v;
      v = VECS[i];
      run_line(v[6], v[5], v[4:1], v[0], BASE - int'(v[4:1]) + LINE_CLK + 12,
               (v[0] ? "R2 enabled line" : (v[6] ? "R8 line disabled" : "R7 global disabled")));
    end

    // R9: sync arrives on the sampling clock of bit 100
    s5 = BASE - 5;
    run_line(1'b1, 1'b1, 4'd5, 1'b1, s5 + bstart(100) + 1, "R9 aborted line");
    run_line(1'b1, 1'b1, 4'd5, 1'b1, s5 + LINE_CLK + 12, "R9 restarted line");

    // R10: sync during the wait phase
    run_line(1'b1, 1'b1, 4'd2, 1'b1, 100, "R10 wait interrupted");
    run_line(1'b1, 1'b1, 4'd9, 1'b1, BASE - 9 + LINE_CLK + 12, "R10 restarted count");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule